// File: doc/BRIEF.md
# MDIO Management Master

This block lets a host read and write the registers of an Ethernet PHY over the two-wire MDC/MDIO management bus. The host sees a small bank of registers through a plain write-enable / address / data port. Reads of that bank are combinational. MDC is a divided copy of the system clock. A three-bit select field chooses the divide ratio from a fixed, non-uniform list. Software should pick the smallest ratio that keeps MDC at or below the PHY's limit.

A write transaction starts as soon as the host writes the write-data register. A read transaction starts when the host sets the read bit of the command register. The host polls the busy bit until it drops, collects the result from the read-data register, and then clears the command bit itself. Each transaction sends 32 preamble ones and then a 32-bit frame, most significant bit first. The frame holds the start code 01, the opcode, the PHY address, the register number, a two-bit turnaround and 16 data bits. A hold bit in the configuration register keeps the divider and the sequencer in reset for as long as it is set.

Top module: `mdio_mgmt_master`

## Requirements
- R1: MDC has a 50 % duty cycle and its period in system clocks is 4, 6, 8, 10, 14, 20 or 28 for select values 0 to 6, and 28 for select value 7. MDC is low after reset.
- R2: While the hold bit (bit 3 at offset 0) is 1, MDC stays low and busy stays 0. A frame in flight is abandoned, and writes that would start a transaction are ignored, including the write-data register update.
- R3: The address register at offset 2 holds the PHY address in bits 12:8 and the register number in bits 4:0, and reads back those two fields.
- R4: A host write to offset 3 stores bits 15:0 and starts a write frame: 32 ones, 01, 01, PHY address, register number, 10, then the 16 data bits, MSB first. MDIO is driven for all 64 bits.
- R5: A host write to offset 1 with bit 0 set starts a read frame with opcode 10. MDIO is released from the first turnaround bit (frame bit 46 of 64) to the end. The command bit keeps its value until the host rewrites it.
- R6: MDIO changes only when MDC falls. Read data is sampled when MDC rises during the last 16 bits, and the 16-bit result appears at offset 4 when busy drops.
- R7: Busy (bit 0 at offset 5) rises on the clock after the starting write. It falls at the falling MDC edge that ends the 64th bit.
- R8: While busy is 1, writes to offset 1 and offset 3 leave the registers unchanged and do not start or alter a frame.
- R9: Offset 0 reads the select field in bits 2:0 (reset value 6) and the hold bit in bit 3 (reset value 0). Offsets 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWrEn | input | 1 | Host register write strobe |
| hostAddr | input | 3 | Host register offset |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Combinational read data for hostAddr |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | MDIO output value |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO input from the pad |

## Verification
Write frames are sent with the data words A5C3, 0000 and FFFF, so that a stuck shifter, an inverted bit order or a missing turnaround shows up against a reference MDIO waveform on every clock. Reads return BEEF and 0001 from a modelled PHY, which separates sampling at the wrong MDC edge or the wrong bit slot from correct capture. The MDC period is measured for all eight select codes, which catches errors in the ratio table. Further patterns cover a second write and a second read issued mid-frame, and the hold bit raised mid-frame and followed by a write while held, which show whether ignored commands stay without effect.

// File: rtl/mdio_mgmt_pkg.sv
`timescale 1ns/1ps
package mdio_mgmt_pkg;

  typedef struct packed {
    logic load;      // capture a new frame word
    logic shift;     // advance to the next frame bit
    logic sample;    // take one read-data bit from MDIO
    logic commit;    // publish the captured read word
    logic drive;     // MDIO output enable
    logic preamble;  // output the idle/preamble one
  } mdioStrobe_t;

  // half period of MDC in system clocks for each select code
  function automatic int halfRatio(input logic [2:0] sel);
    case (sel)
      3'd0:    return 2;
      3'd1:    return 3;
      3'd2:    return 4;
      3'd3:    return 5;
      3'd4:    return 7;
      3'd5:    return 10;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/mdio_clk_div.sv
`timescale 1ns/1ps
module mdio_clk_div #(
  parameter int CNT_W = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hold,
  input  logic [2:0] sel,
  output logic       mdc,
  output logic       fallTick,
  output logic       riseTick
);
  import mdio_mgmt_pkg::*;

  logic [CNT_W-1:0] divCnt;
  logic [CNT_W-1:0] lastCnt;
  logic             wrap;

  assign lastCnt  = CNT_W'(halfRatio(sel) - 1);
  assign wrap     = (divCnt >= lastCnt);
  assign fallTick = wrap && mdc && !hold;
  assign riseTick = wrap && !mdc && !hold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      mdc    <= 1'b0;
    end else if (hold) begin
      divCnt <= '0;
      mdc    <= 1'b0;
    end else if (wrap) begin
      divCnt <= '0;
      mdc    <= ~mdc;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  AST_MDC_HELD_LOW: assert property (@(posedge clk) disable iff (!rstN)
    hold |=> !mdc); // R2

endmodule

// File: rtl/mdio_seq_ctrl.sv
`timescale 1ns/1ps
module mdio_seq_ctrl #(
  parameter int PRE_BITS   = 32,
  parameter int FRAME_BITS = 32,
  parameter int DATA_BITS  = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       hold,
  input  logic                       startReq,
  input  logic                       startRead,
  input  logic                       fallTick,
  input  logic                       riseTick,
  output logic                       busy,
  output mdio_mgmt_pkg::mdioStrobe_t strobe
);
  localparam int TOTAL    = PRE_BITS + FRAME_BITS;
  localparam int IDX_W    = $clog2(TOTAL);
  localparam int TA_POS   = TOTAL - DATA_BITS - 2;
  localparam int DATA_POS = TOTAL - DATA_BITS;

  logic             started;
  logic             isRead;
  logic [IDX_W-1:0] bitIdx;
  logic             startAccept;
  logic             lastBit;

  assign startAccept = startReq && !busy && !hold;
  assign lastBit     = (bitIdx == IDX_W'(TOTAL - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      started <= 1'b0;
      isRead  <= 1'b0;
      bitIdx  <= '0;
    end else if (hold) begin
      busy    <= 1'b0;
      started <= 1'b0;
      isRead  <= 1'b0;
      bitIdx  <= '0;
    end else if (startAccept) begin
      busy    <= 1'b1;
      started <= 1'b0;
      isRead  <= startRead;
      bitIdx  <= '0;
    end else if (busy && fallTick) begin
      if (!started) begin
        started <= 1'b1;
        bitIdx  <= '0;
      end else if (lastBit) begin
        busy    <= 1'b0;
        started <= 1'b0;
      end else begin
        bitIdx  <= bitIdx + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.load     = startAccept;
    strobe.shift    = busy && started && fallTick && !lastBit &&
                      (bitIdx >= IDX_W'(PRE_BITS));
    strobe.sample   = busy && started && riseTick && isRead &&
                      (bitIdx >= IDX_W'(DATA_POS));
    strobe.commit   = busy && started && fallTick && lastBit && isRead;
    strobe.drive    = busy && started && !(isRead && (bitIdx >= IDX_W'(TA_POS)));
    strobe.preamble = !started || (bitIdx < IDX_W'(PRE_BITS));
  end

  AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq && !fallTick && !hold) |=> (busy && $stable(isRead) && $stable(bitIdx))); // R8
  AST_BUSY_ENDS_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(fallTick) || $past(hold))); // R7
  AST_SAMPLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sample |-> !strobe.drive); // R5

endmodule

// File: rtl/mdio_shift_path.sv
`timescale 1ns/1ps
module mdio_shift_path #(
  parameter int FRAME_BITS = 32,
  parameter int DATA_BITS  = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  mdio_mgmt_pkg::mdioStrobe_t  strobe,
  input  logic [FRAME_BITS-1:0]       loadWord,
  input  logic                        mdioIn,
  output logic                        mdioOut,
  output logic                        mdioOe,
  output logic [DATA_BITS-1:0]        rdData
);
  logic [FRAME_BITS-1:0] txWord;
  logic [DATA_BITS-1:0]  capWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txWord  <= '0;
      capWord <= '0;
      rdData  <= '0;
    end else begin
      if (strobe.load)
        txWord <= loadWord;
      else if (strobe.shift)
        txWord <= {txWord[FRAME_BITS-2:0], 1'b0};
      if (strobe.sample)
        capWord <= {capWord[DATA_BITS-2:0], mdioIn};
      if (strobe.commit)
        rdData <= capWord;
    end
  end

  assign mdioOut = strobe.preamble ? 1'b1 : txWord[FRAME_BITS-1];
  assign mdioOe  = strobe.drive;

endmodule

// File: rtl/mdio_mgmt_master.sv
`timescale 1ns/1ps
module mdio_mgmt_master #(
  parameter int ADDR_W    = 3,
  parameter int HOST_W    = 32,
  parameter int PHY_W     = 5,
  parameter int REG_W     = 5,
  parameter int DATA_BITS = 16,
  parameter int PRE_BITS  = 32,
  parameter int CNT_W     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [HOST_W-1:0] hostWrData,
  output logic [HOST_W-1:0] hostRdData,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);
  import mdio_mgmt_pkg::*;

  localparam int FRAME_BITS = 6 + PHY_W + REG_W + DATA_BITS;
  localparam int PHY_LSB    = 8;
  localparam logic [ADDR_W-1:0] OFS_CFG   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_CMD   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFS_ADDR  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFS_WDATA = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] OFS_RDATA = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_IND   = ADDR_W'(5);

  logic [2:0]            cfgSel;
  logic                  cfgHold;
  logic                  cmdRead;
  logic [PHY_W-1:0]      phyAddr;
  logic [REG_W-1:0]      regAddr;
  logic [DATA_BITS-1:0]  wrData;
  logic [DATA_BITS-1:0]  rdData;
  logic                  busy;
  logic                  fallTick;
  logic                  riseTick;
  logic                  wrCfg, wrCmd, wrAddr, wrWdata;
  logic                  startReq;
  logic [FRAME_BITS-1:0] loadWord;
  mdioStrobe_t           strobe;

  assign wrCfg    = hostWrEn && (hostAddr == OFS_CFG);
  assign wrCmd    = hostWrEn && (hostAddr == OFS_CMD);
  assign wrAddr   = hostWrEn && (hostAddr == OFS_ADDR);
  assign wrWdata  = hostWrEn && (hostAddr == OFS_WDATA);
  assign startReq = (wrCmd && hostWrData[0]) || wrWdata;

  // frame word: start, opcode, PHY, register, turnaround, data
  assign loadWord = wrCmd
    ? {2'b01, 2'b10, phyAddr, regAddr, 2'b00, {DATA_BITS{1'b0}}}
    : {2'b01, 2'b01, phyAddr, regAddr, 2'b10, hostWrData[DATA_BITS-1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgSel  <= 3'd6;
      cfgHold <= 1'b0;
      cmdRead <= 1'b0;
      phyAddr <= '0;
      regAddr <= '0;
      wrData  <= '0;
    end else begin
      if (wrCfg) begin
        cfgSel  <= hostWrData[2:0];
        cfgHold <= hostWrData[3];
      end
      if (wrCmd && !busy)
        cmdRead <= hostWrData[0];
      if (wrAddr) begin
        phyAddr <= hostWrData[PHY_LSB +: PHY_W];
        regAddr <= hostWrData[REG_W-1:0];
      end
      if (wrWdata && !busy && !cfgHold)
        wrData <= hostWrData[DATA_BITS-1:0];
    end
  end

  always_comb begin
    hostRdData = '0;
    case (hostAddr)
      OFS_CFG:   hostRdData[3:0] = {cfgHold, cfgSel};
      OFS_CMD:   hostRdData[0] = cmdRead;
      OFS_ADDR:  begin
                   hostRdData[PHY_LSB +: PHY_W] = phyAddr;
                   hostRdData[REG_W-1:0]        = regAddr;
                 end
      OFS_WDATA: hostRdData[DATA_BITS-1:0] = wrData;
      OFS_RDATA: hostRdData[DATA_BITS-1:0] = rdData;
      OFS_IND:   hostRdData[0] = busy;
      default:   hostRdData = '0;
    endcase
  end

  mdio_clk_div #(.CNT_W(CNT_W)) i_clkDiv (
    .clk      (clk),
    .rstN     (rstN),
    .hold     (cfgHold),
    .sel      (cfgSel),
    .mdc      (mdc),
    .fallTick (fallTick),
    .riseTick (riseTick)
  );

  mdio_seq_ctrl #(
    .PRE_BITS   (PRE_BITS),
    .FRAME_BITS (FRAME_BITS),
    .DATA_BITS  (DATA_BITS)
  ) i_seqCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .hold      (cfgHold),
    .startReq  (startReq),
    .startRead (wrCmd),
    .fallTick  (fallTick),
    .riseTick  (riseTick),
    .busy      (busy),
    .strobe    (strobe)
  );

  mdio_shift_path #(
    .FRAME_BITS (FRAME_BITS),
    .DATA_BITS  (DATA_BITS)
  ) i_shiftPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .loadWord (loadWord),
    .mdioIn   (mdioIn),
    .mdioOut  (mdioOut),
    .mdioOe   (mdioOe),
    .rdData   (rdData)
  );

  AST_OUT_STABLE_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (mdc && $past(mdc)) |-> ($stable(mdioOut) && $stable(mdioOe))); // R6

endmodule

// File: tb/test_mdio_mgmt_master.sv
`timescale 1ns/1ps
module test_mdio_mgmt_master;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [2:0]  hostAddr = 3'd5;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  int tests = 0;
  int fails = 0;
  bit cmpOn = 0;
  bit finished = 0;

  mdio_mgmt_master i_mdio_mgmt_master (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  always #2.5 clk = ~clk;

  // ---------------- reference model ----------------
  int        mSel, mCnt, mPos;
  bit        mHold, mMdc, mBusy, mRd, mCmd;
  bit [4:0]  mPhy, mReg;
  bit [15:0] mWr, mRdData, mCap, resp;
  bit [31:0] mFrame;

  function automatic int ratioOf(input int s);
    int tbl[7] = '{4, 6, 8, 10, 14, 20, 28};
    return (s > 6) ? 28 : tbl[s];
  endfunction

  always @(posedge clk) begin
    int  half;
    bit  tick, fall, rise, oldBusy;
    if (!rstN) begin
      mSel = 6; mHold = 0; mCnt = 0; mMdc = 0; mBusy = 0; mPos = -1; mRd = 0;
      mCmd = 0; mPhy = 0; mReg = 0; mWr = 0; mRdData = 0; mCap = 0; mFrame = 0;
    end else begin
      half = ratioOf(mSel) / 2;
      tick = (mCnt >= half - 1);
      fall = tick && mMdc;
      rise = tick && !mMdc;
      oldBusy = mBusy;
      if (mHold) begin
        mCnt = 0; mMdc = 0; mBusy = 0; mPos = -1;
      end else begin
        if (mBusy && mRd && mPos >= 48 && rise) mCap = {mCap[14:0], mdioIn};
        if (mBusy && fall) begin
          if (mPos == 63) begin
            mBusy = 0; mPos = -1;
            if (mRd) mRdData = mCap;
          end else mPos++;
        end
        if (!oldBusy && hostWrEn && ((hostAddr == 1 && hostWrData[0]) || hostAddr == 3)) begin
          mBusy = 1; mPos = -1; mRd = (hostAddr == 1);
          mFrame = mRd ? {4'b0110, mPhy, mReg, 18'h0}
                       : {4'b0101, mPhy, mReg, 2'b10, hostWrData[15:0]};
        end
        if (tick) begin mCnt = 0; mMdc = !mMdc; end
        else mCnt++;
      end
      if (hostWrEn) begin
        case (hostAddr)
          3'd0: begin mSel = hostWrData[2:0]; mHold = hostWrData[3]; end
          3'd1: if (!oldBusy) mCmd = hostWrData[0];
          3'd2: begin mPhy = hostWrData[12:8]; mReg = hostWrData[4:0]; end
          3'd3: if (!oldBusy && !mHold) mWr = hostWrData[15:0];
          default: ;
        endcase
      end
    end
  end

  // modelled PHY answering during the data bits of a read
  always @(negedge clk)
    mdioIn <= (mBusy && mRd && mPos >= 48) ? resp[63 - mPos] : 1'b1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    bit expOe, expOut;
    #1;
    if (cmpOn) begin
      expOe  = mBusy && mPos >= 0 && !(mRd && mPos >= 46);
      expOut = (mBusy && mPos >= 32) ? mFrame[63 - mPos] : 1'b1;
      chk("R1 mdc", 32'(mdc), 32'(mMdc));
      chk("R5 mdioOe", 32'(mdioOe), 32'(expOe));
      if (expOe) chk("R4 mdioOut", 32'(mdioOut), 32'(expOut));
      if (hostAddr == 3'd5) chk("R7 busy", 32'(hostRdData[0]), 32'(mBusy));
    end
  end

  task automatic hostWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0; hostAddr = 3'd5; hostWrData = '0;
  endtask

  task automatic hostRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    hostAddr = a;
    #2;
    d = hostRdData;
    hostAddr = 3'd5;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 4000; i++) begin
      hostRead(3'd5, v);
      if (v[0] == 1'b0) break;
    end
  endtask

  task automatic measurePeriod(output int p);
    logic prev;
    prev = mdc;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (mdc && !prev) break;
      prev = mdc;
    end
    p = 0;
    prev = mdc;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      p++;
      if (mdc && !prev) break;
      prev = mdc;
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(5 * 150000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    logic [31:0] v;
    int p;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    hostRead(3'd0, v); chk("R9 cfg reset", v, 32'h6);
    hostRead(3'd5, v); chk("R7 busy reset", v, 32'h0);
    chk("R1 mdc reset", 32'(mdc), 32'h0);
    chk("R5 oe reset", 32'(mdioOe), 32'h0);
    cmpOn = 1;

    for (int s = 0; s < 8; s++) begin
      hostWrite(3'd0, 32'(s));
      measurePeriod(p);
      chk("R1 mdc period", 32'(p), 32'(ratioOf(s)));
    end

    hostWrite(3'd0, 32'h0);
    hostWrite(3'd2, 32'hFFFF_F5EA);
    hostRead(3'd2, v); chk("R3 addr fields", v, 32'h0000_150A);

    // write frame, with a second write attempted mid-frame
    hostWrite(3'd3, 32'h0000_A5C3);
    repeat (40) @(negedge clk);
    hostWrite(3'd3, 32'h0000_1234);
    hostWrite(3'd1, 32'h1);
    hostRead(3'd3, v); chk("R8 wdata kept", v, 32'h0000_A5C3);
    hostRead(3'd1, v); chk("R8 cmd kept", v, 32'h0);
    waitIdle();
    hostRead(3'd3, v); chk("R4 wdata readback", v, 32'h0000_A5C3);

    hostWrite(3'd3, 32'h0000_0000); waitIdle();
    hostWrite(3'd3, 32'h0000_FFFF); waitIdle();

    // read frames
    resp = 16'hBEEF;
    hostWrite(3'd1, 32'h1);
    waitIdle();
    hostRead(3'd4, v); chk("R6 read data", v, 32'h0000_BEEF);
    hostRead(3'd1, v); chk("R5 cmd held", v, 32'h1);
    hostWrite(3'd1, 32'h0);
    hostRead(3'd1, v); chk("R5 cmd cleared", v, 32'h0);

    hostWrite(3'd2, 32'h0000_0113);
    resp = 16'h0001;
    hostWrite(3'd1, 32'h1);
    repeat (30) @(negedge clk);
    hostWrite(3'd3, 32'h0000_7777);
    waitIdle();
    hostRead(3'd4, v); chk("R6 read data 2", v, 32'h0000_0001);
    hostWrite(3'd1, 32'h0);

    // hold mid-frame
    hostWrite(3'd3, 32'h0000_3C3C);
    repeat (50) @(negedge clk);
    hostWrite(3'd0, 32'h8);
    repeat (2) @(negedge clk);
    hostRead(3'd5, v); chk("R2 busy in hold", v, 32'h0);
    chk("R2 mdc in hold", 32'(mdc), 32'h0);
    hostWrite(3'd3, 32'h0000_9999);
    repeat (5) @(negedge clk);
    hostRead(3'd5, v); chk("R2 no start in hold", v, 32'h0);
    hostRead(3'd3, v); chk("R2 wdata kept in hold", v, 32'h0000_3C3C);
    chk("R2 oe in hold", 32'(mdioOe), 32'h0);
    hostWrite(3'd0, 32'h0);
    hostRead(3'd0, v); chk("R9 cfg readback", v, 32'h0);
    hostRead(3'd6, v); chk("R9 unmapped 6", v, 32'h0);
    hostRead(3'd7, v); chk("R9 unmapped 7", v, 32'h0);

    repeat (10) @(negedge clk);
    finish();
  end

endmodule